// File: doc/BRIEF.md
# Memory Map Router with Stall Hold

This block sits between a pipelined processor and everything it can address. Each data access is steered by the top four address bits to one of several places: the data cache, a boot ROM, an uncached bypass path, or a small set of peripheral registers. The peripheral registers cover a serial port, a free-running cycle counter, a retired-instruction counter and the argument and start registers of a drawing engine. In parallel the block fetches the instruction at `pc_i` through the instruction cache.

The data and fetch ports each have a tracker that issues exactly one request per access and waits for the matching response. The block raises `stall_o` until every open access has its response. A response that arrives while the other port, or an external stall (`stall_ext_i`), still holds the pipeline is captured. It then stays on the output unchanged, so both results are on hand in the cycle the stall ends. The processor keeps its request inputs steady while `stall_o` or `stall_ext_i` is high. An access completes at the first clock edge where both are low.

Top module: `mem_router`

## Requirements
- R1: Address nibble [31:28] equal to 0x1 or 0x3 routes to the data cache. 0x4 reads route to the boot ROM. 0x9 through 0xF route to the bypass path. Each access raises exactly one single-cycle request on exactly one target. `mem_addr_o`, `mem_we_o` and `mem_wdata_o` carry the access. A read returns the target's response data.
- R2: Nibbles 0x0, 0x2, 0x5, 0x6 and 0x7 raise no request, read as zero and complete without stalling. Writes to the ROM region (0x4) are dropped without a request and complete without stalling.
- R3: `stall_o` is high from the cycle a request is issued through the cycle before its target's response. With no other stall source, an access with target latency L therefore completes L cycles after issue. Peripheral accesses (nibble 0x8) complete in their issue cycle.
- R4: A response arriving while the other port or `stall_ext_i` keeps the pipeline stalled is held unchanged on `d_rdata_o` / `instr_o` until the stall ends, and the request is not issued again. A peripheral read returns the value from its issue cycle.
- R5: When `if_req_i` is high, one instruction-cache request is issued with address `pc_i`, and `instr_o` returns its data.
- R6: The cycle counter (peripheral byte offset 0x10, taken from address bits [7:2]) increments on every clock. A write to it clears it, so a read issued k cycles after the clearing write's issue cycle returns k-1.
- R7: The instruction counter (offset 0x14) counts clock cycles with `retire_i` high. A write to it clears it to zero.
- R8: The serial status register (offset 0x00) reads transmit-ready (`uart_tx_ready_i`) in bit 0 and receive-valid in bit 1. A `uart_rx_valid_i` pulse latches the byte and sets receive-valid. A read of offset 0x04 returns the byte in bits [7:0] and clears receive-valid.
- R9: A write to offset 0x08 while `uart_tx_ready_i` is high pulses `uart_tx_valid_o` for one cycle with `wdata[7:0]`. While not ready, the write gives no pulse.
- R10: Drawing argument i sits at offset 0x40+4*i and can be read and written. It appears on `gfx_args_o[32*i +: 32]`. A write to offset 0x24 pulses `gfx_start_o` for one cycle. Offset 0x20 reads `gfx_busy_i` in bit 0.
- R11: Writes to the read-only offsets 0x00, 0x04 and 0x20 change nothing. Reads of the write-only offsets 0x08 and 0x24, and of unassigned peripheral offsets, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_req_i | input | 1 | Fetch wanted this step |
| pc_i | input | 32 | Fetch address |
| instr_o | output | 32 | Fetched instruction |
| d_req_i | input | 1 | Data access wanted this step |
| d_we_i | input | 1 | Data access is a write |
| d_addr_i | input | 32 | Data address |
| d_wdata_i | input | 32 | Write data |
| d_rdata_o | output | 32 | Read data |
| stall_ext_i | input | 1 | Stall raised elsewhere in the pipeline |
| stall_o | output | 1 | Router waiting on a response |
| retire_i | input | 1 | A non-bubble instruction retires this cycle |
| ic_req_o | output | 1 | Instruction cache request |
| ic_addr_o | output | 32 | Instruction cache address |
| ic_rvalid_i | input | 1 | Instruction cache response |
| ic_rdata_i | input | 32 | Instruction cache data |
| mem_addr_o | output | 32 | Shared memory address |
| mem_we_o | output | 1 | Shared memory write enable |
| mem_wdata_o | output | 32 | Shared memory write data |
| dc_req_o | output | 1 | Data cache request |
| dc_rvalid_i | input | 1 | Data cache response |
| dc_rdata_i | input | 32 | Data cache data |
| rom_req_o | output | 1 | Boot ROM request |
| rom_rvalid_i | input | 1 | Boot ROM response |
| rom_rdata_i | input | 32 | Boot ROM data |
| by_req_o | output | 1 | Bypass request |
| by_rvalid_i | input | 1 | Bypass response |
| by_rdata_i | input | 32 | Bypass data |
| uart_tx_ready_i | input | 1 | Serial transmitter can take a byte |
| uart_tx_valid_o | output | 1 | Byte offered to transmitter |
| uart_tx_data_o | output | 8 | Byte to transmit |
| uart_rx_valid_i | input | 1 | Received byte pulse |
| uart_rx_data_i | input | 8 | Received byte |
| gfx_busy_i | input | 1 | Drawing engine busy |
| gfx_start_o | output | 1 | Drawing command start pulse |
| gfx_args_o | output | 128 | Drawing arguments, 4 x 32 |

## Verification
The main targets are overlapping stalls. A fast data response must survive while a slow fetch, or an external stall, keeps the pipeline frozen. A design without the capture would hand back stale or absent data, or issue the cache request again; either shows up as wrong read data or a doubled request count. A cycle-counter read under an external stall must return its issue-cycle value; a live path would return a value higher by the stall length. The bench also probes read side effects and dropped writes. Clearing receive-valid twice, or on a write, would lose a byte. ROM writes and unmapped nibbles must issue no request, or a cache would see traffic it never should.

// File: rtl/mem_router_pkg.sv
package mem_router_pkg;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_DCACHE,
    TGT_ROM,
    TGT_IO,
    TGT_BYPASS
  } tgt_e;

  typedef enum logic [1:0] {
    TRK_IDLE,
    TRK_WAIT,
    TRK_DONE
  } trk_e;

  localparam int unsigned IO_OFF_W = 6;  // word offset from addr[7:2]

  localparam logic [IO_OFF_W-1:0] IO_UART_STAT = 6'h00;
  localparam logic [IO_OFF_W-1:0] IO_UART_RX   = 6'h01;
  localparam logic [IO_OFF_W-1:0] IO_UART_TX   = 6'h02;
  localparam logic [IO_OFF_W-1:0] IO_CYC       = 6'h04;
  localparam logic [IO_OFF_W-1:0] IO_INSTR     = 6'h05;
  localparam logic [IO_OFF_W-1:0] IO_GFX_STAT  = 6'h08;
  localparam logic [IO_OFF_W-1:0] IO_GFX_GO    = 6'h09;
  localparam logic [IO_OFF_W-1:0] IO_GFX_ARG0  = 6'h10;
  localparam int unsigned         GFX_MAX_ARGS = 16;

endpackage

// File: rtl/mr_decode.sv
module mr_decode
  import mem_router_pkg::*;
(
  input  logic [3:0] nib_i,
  output tgt_e       tgt_o
);

  always_comb begin
    if (nib_i >= 4'h9) begin
      tgt_o = TGT_BYPASS;
    end else begin
      unique case (nib_i)
        4'h1, 4'h3: tgt_o = TGT_DCACHE;
        4'h4:       tgt_o = TGT_ROM;
        4'h8:       tgt_o = TGT_IO;
        default:    tgt_o = TGT_NONE;
      endcase
    end
  end

endmodule

// File: rtl/mr_port_track.sv
module mr_port_track
  import mem_router_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              resp_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              advance_i,
  output logic              issue_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);

  trk_e              st_q;
  logic [DATA_W-1:0] hold_q;

  assign issue_o = req_i && (st_q == TRK_IDLE);
  assign done_o  = !req_i || (st_q == TRK_DONE) || resp_i;
  assign data_o  = (st_q == TRK_DONE) ? hold_q : rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= TRK_IDLE;
      hold_q <= '0;
    end else if (advance_i) begin
      st_q <= TRK_IDLE;
    end else if (req_i && (st_q != TRK_DONE) && resp_i) begin
      st_q   <= TRK_DONE;  // capture while the pipeline stays frozen
      hold_q <= rdata_i;
    end else if (issue_o) begin
      st_q <= TRK_WAIT;
    end
  end

  p_issue_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && !advance_i) |=> !issue_o);

  p_hold_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && done_o && !advance_i) |=> (!req_i || data_o == $past(data_o)));

endmodule

// File: rtl/mr_io_regs.sv
module mr_io_regs
  import mem_router_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned GFX_ARGS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic                       re_i,
  input  logic [IO_OFF_W-1:0]        off_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       retire_i,
  input  logic                       uart_tx_ready_i,
  output logic                       uart_tx_valid_o,
  output logic [7:0]                 uart_tx_data_o,
  input  logic                       uart_rx_valid_i,
  input  logic [7:0]                 uart_rx_data_i,
  input  logic                       gfx_busy_i,
  output logic                       gfx_start_o,
  output logic [GFX_ARGS*DATA_W-1:0] gfx_args_o,
  output logic [DATA_W-1:0]          rdata_o
);

  logic [CNT_W-1:0]  cyc_q, ins_q;
  logic              rx_full_q;
  logic [7:0]        rx_byte_q;
  logic [DATA_W-1:0] arg_q [GFX_ARGS];

  wire cyc_clr = we_i && (off_i == IO_CYC);
  wire ins_clr = we_i && (off_i == IO_INSTR);
  wire rx_take = re_i && (off_i == IO_UART_RX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      ins_q <= '0;
    end else begin
      cyc_q <= cyc_clr ? '0 : cyc_q + 1'b1;
      if (ins_clr)       ins_q <= '0;
      else if (retire_i) ins_q <= ins_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_full_q <= 1'b0;
      rx_byte_q <= '0;
    end else if (uart_rx_valid_i) begin
      rx_full_q <= 1'b1;
      rx_byte_q <= uart_rx_data_i;
    end else if (rx_take) begin
      rx_full_q <= 1'b0;
    end
  end

  assign uart_tx_valid_o = we_i && (off_i == IO_UART_TX) && uart_tx_ready_i;
  assign uart_tx_data_o  = wdata_i[7:0];
  assign gfx_start_o     = we_i && (off_i == IO_GFX_GO);

  for (genvar g = 0; g < GFX_ARGS; g++) begin : g_arg
    localparam logic [IO_OFF_W-1:0] ArgOff = IO_GFX_ARG0 + IO_OFF_W'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        arg_q[g] <= '0;
      else if (we_i && (off_i == ArgOff)) arg_q[g] <= wdata_i;
    end
    assign gfx_args_o[g*DATA_W +: DATA_W] = arg_q[g];
  end

  always_comb begin
    rdata_o = '0;
    unique case (off_i)
      IO_UART_STAT: begin
        rdata_o[0] = uart_tx_ready_i;
        rdata_o[1] = rx_full_q;
      end
      IO_UART_RX:  rdata_o[7:0] = rx_byte_q;
      IO_CYC:      rdata_o = DATA_W'(cyc_q);
      IO_INSTR:    rdata_o = DATA_W'(ins_q);
      IO_GFX_STAT: rdata_o[0] = gfx_busy_i;
      default: begin
        for (int i = 0; i < GFX_ARGS; i++) begin
          if (off_i == IO_GFX_ARG0 + IO_OFF_W'(i)) rdata_o = arg_q[i];
        end
      end
    endcase
  end

  p_cyc_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_clr |=> (cyc_q == '0));

  p_ins_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_clr |=> (ins_q == '0));

  p_rx_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_take && !uart_rx_valid_i) |=> !rx_full_q);

  p_ro_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (off_i == IO_UART_RX || off_i == IO_UART_STAT) && !uart_rx_valid_i)
      |=> $stable({rx_full_q, rx_byte_q}));

endmodule

// File: rtl/mem_router.sv
module mem_router
  import mem_router_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned GFX_ARGS = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       if_req_i,
  input  logic [ADDR_W-1:0]          pc_i,
  output logic [DATA_W-1:0]          instr_o,
  input  logic                       d_req_i,
  input  logic                       d_we_i,
  input  logic [ADDR_W-1:0]          d_addr_i,
  input  logic [DATA_W-1:0]          d_wdata_i,
  output logic [DATA_W-1:0]          d_rdata_o,
  input  logic                       stall_ext_i,
  output logic                       stall_o,
  input  logic                       retire_i,
  output logic                       ic_req_o,
  output logic [ADDR_W-1:0]          ic_addr_o,
  input  logic                       ic_rvalid_i,
  input  logic [DATA_W-1:0]          ic_rdata_i,
  output logic [ADDR_W-1:0]          mem_addr_o,
  output logic                       mem_we_o,
  output logic [DATA_W-1:0]          mem_wdata_o,
  output logic                       dc_req_o,
  input  logic                       dc_rvalid_i,
  input  logic [DATA_W-1:0]          dc_rdata_i,
  output logic                       rom_req_o,
  input  logic                       rom_rvalid_i,
  input  logic [DATA_W-1:0]          rom_rdata_i,
  output logic                       by_req_o,
  input  logic                       by_rvalid_i,
  input  logic [DATA_W-1:0]          by_rdata_i,
  input  logic                       uart_tx_ready_i,
  output logic                       uart_tx_valid_o,
  output logic [7:0]                 uart_tx_data_o,
  input  logic                       uart_rx_valid_i,
  input  logic [7:0]                 uart_rx_data_i,
  input  logic                       gfx_busy_i,
  output logic                       gfx_start_o,
  output logic [GFX_ARGS*DATA_W-1:0] gfx_args_o
);

  tgt_e              tgt;
  logic              d_resp, d_issue, d_done, if_issue, if_done, advance;
  logic [DATA_W-1:0] d_live, io_rdata;

  mr_decode u_decode (
    .nib_i (d_addr_i[ADDR_W-1 -: 4]),
    .tgt_o (tgt)
  );

  always_comb begin
    unique case (tgt)
      TGT_DCACHE: begin d_resp = dc_rvalid_i;                 d_live = dc_rdata_i;  end
      TGT_ROM:    begin d_resp = d_we_i ? 1'b1 : rom_rvalid_i; d_live = rom_rdata_i; end
      TGT_BYPASS: begin d_resp = by_rvalid_i;                 d_live = by_rdata_i;  end
      TGT_IO:     begin d_resp = 1'b1;                        d_live = io_rdata;    end
      default:    begin d_resp = 1'b1;                        d_live = '0;          end
    endcase
  end

  assign stall_o = !(if_done && d_done);
  assign advance = !stall_o && !stall_ext_i;

  mr_port_track #(.DATA_W(DATA_W)) u_fetch_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (if_req_i),
    .resp_i    (ic_rvalid_i),
    .rdata_i   (ic_rdata_i),
    .advance_i (advance),
    .issue_o   (if_issue),
    .done_o    (if_done),
    .data_o    (instr_o)
  );

  mr_port_track #(.DATA_W(DATA_W)) u_data_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (d_req_i),
    .resp_i    (d_resp),
    .rdata_i   (d_live),
    .advance_i (advance),
    .issue_o   (d_issue),
    .done_o    (d_done),
    .data_o    (d_rdata_o)
  );

  assign ic_req_o    = if_issue;
  assign ic_addr_o   = pc_i;
  assign mem_addr_o  = d_addr_i;
  assign mem_we_o    = d_we_i;
  assign mem_wdata_o = d_wdata_i;
  assign dc_req_o    = d_issue && (tgt == TGT_DCACHE);
  assign rom_req_o   = d_issue && (tgt == TGT_ROM) && !d_we_i;
  assign by_req_o    = d_issue && (tgt == TGT_BYPASS);

  mr_io_regs #(
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .GFX_ARGS (GFX_ARGS)
  ) u_io (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .we_i            (d_issue && (tgt == TGT_IO) && d_we_i),
    .re_i            (d_issue && (tgt == TGT_IO) && !d_we_i),
    .off_i           (d_addr_i[IO_OFF_W+1:2]),
    .wdata_i         (d_wdata_i),
    .retire_i        (retire_i),
    .uart_tx_ready_i (uart_tx_ready_i),
    .uart_tx_valid_o (uart_tx_valid_o),
    .uart_tx_data_o  (uart_tx_data_o),
    .uart_rx_valid_i (uart_rx_valid_i),
    .uart_rx_data_i  (uart_rx_data_i),
    .gfx_busy_i      (gfx_busy_i),
    .gfx_start_o     (gfx_start_o),
    .gfx_args_o      (gfx_args_o),
    .rdata_o         (io_rdata)
  );

  p_one_target_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dc_req_o, rom_req_o, by_req_o}));

  p_miss_stalls_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dc_req_o && !dc_rvalid_i) || (by_req_o && !by_rvalid_i)) |-> stall_o);

  p_fetch_stalls_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ic_req_o && !ic_rvalid_i) |-> stall_o);

  initial begin
    a_args_fit_r10: assert (GFX_ARGS >= 1 && GFX_ARGS <= GFX_MAX_ARGS && CNT_W <= DATA_W);
  end

endmodule

// File: tb/mem_router_bench.sv
module mem_router_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        if_req = 0, d_req = 0, d_we = 0, stall_ext = 0, retire = 0;
  logic [31:0] pc = 0, d_addr = 0, d_wdata = 0;
  logic [31:0] instr, d_rdata, ic_addr, mem_addr, mem_wdata;
  logic        stall, ic_req, mem_we, dc_req, rom_req, by_req;
  logic        ic_rvalid, dc_rvalid, rom_rvalid, by_rvalid;
  logic [31:0] ic_rdata, dc_rdata, rom_rdata, by_rdata;
  logic        tx_ready = 1, tx_valid, rx_valid = 0, gfx_busy = 0, gfx_start;
  logic [7:0]  tx_data, rx_data = 0;
  logic [127:0] gfx_args;

  mem_router u_mem_router (
    .clk_i(clk), .rst_ni(rst_n), .if_req_i(if_req), .pc_i(pc), .instr_o(instr),
    .d_req_i(d_req), .d_we_i(d_we), .d_addr_i(d_addr), .d_wdata_i(d_wdata),
    .d_rdata_o(d_rdata), .stall_ext_i(stall_ext), .stall_o(stall), .retire_i(retire),
    .ic_req_o(ic_req), .ic_addr_o(ic_addr), .ic_rvalid_i(ic_rvalid), .ic_rdata_i(ic_rdata),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .dc_req_o(dc_req), .dc_rvalid_i(dc_rvalid), .dc_rdata_i(dc_rdata),
    .rom_req_o(rom_req), .rom_rvalid_i(rom_rvalid), .rom_rdata_i(rom_rdata),
    .by_req_o(by_req), .by_rvalid_i(by_rvalid), .by_rdata_i(by_rdata),
    .uart_tx_ready_i(tx_ready), .uart_tx_valid_o(tx_valid), .uart_tx_data_o(tx_data),
    .uart_rx_valid_i(rx_valid), .uart_rx_data_i(rx_data),
    .gfx_busy_i(gfx_busy), .gfx_start_o(gfx_start), .gfx_args_o(gfx_args)
  );

  function automatic logic [31:0] mdl(logic [31:0] a, logic [7:0] salt);
    return {a[15:0] ^ {salt, salt}, a[31:16]};
  endfunction

  // responder models: response L cycles after the request
  int ic_lat = 1, dc_lat = 1, rom_lat = 1, by_lat = 1;
  int ic_cnt = 0, dc_cnt = 0, rom_cnt = 0, by_cnt = 0;
  int n_ic = 0, n_dc = 0, n_rom = 0, n_by = 0, n_tx = 0, n_go = 0, cyc_b = 0;
  logic [31:0] ic_a = 0, dc_a = 0, rom_a = 0, by_a = 0;
  logic [7:0]  tx_last = 0;

  always @(posedge clk) begin
    cyc_b <= cyc_b + 1;
    if (ic_req)  begin ic_cnt  <= ic_lat;  ic_a  <= ic_addr;  n_ic  <= n_ic + 1;  end
    else if (ic_cnt > 0)  ic_cnt  <= ic_cnt - 1;
    if (dc_req)  begin dc_cnt  <= dc_lat;  dc_a  <= mem_addr; n_dc  <= n_dc + 1;  end
    else if (dc_cnt > 0)  dc_cnt  <= dc_cnt - 1;
    if (rom_req) begin rom_cnt <= rom_lat; rom_a <= mem_addr; n_rom <= n_rom + 1; end
    else if (rom_cnt > 0) rom_cnt <= rom_cnt - 1;
    if (by_req)  begin by_cnt  <= by_lat;  by_a  <= mem_addr; n_by  <= n_by + 1;  end
    else if (by_cnt > 0)  by_cnt  <= by_cnt - 1;
    if (tx_valid)  begin n_tx <= n_tx + 1; tx_last <= tx_data; end
    if (gfx_start) n_go <= n_go + 1;
  end

  assign ic_rvalid  = (ic_cnt == 1);
  assign dc_rvalid  = (dc_cnt == 1);
  assign rom_rvalid = (rom_cnt == 1);
  assign by_rvalid  = (by_cnt == 1);
  assign ic_rdata   = mdl(ic_a, 8'h5e);
  assign dc_rdata   = mdl(dc_a, 8'h11);
  assign rom_rdata  = mdl(rom_a, 8'h44);
  assign by_rdata   = mdl(by_a, 8'h99);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one pipeline step; k = cycles from issue to completion, t0 = issue cycle
  task automatic acc(input logic fi, input logic [31:0] p, input logic dr, input logic we,
                     input logic [31:0] a, input logic [31:0] wd, input int ext,
                     output logic [31:0] rd, output logic [31:0] ins, output int k,
                     output int t0);
    @(negedge clk);
    if_req = fi; pc = p; d_req = dr; d_we = we; d_addr = a; d_wdata = wd;
    stall_ext = (ext > 0);
    k = 0; t0 = cyc_b;
    forever begin
      #1;
      if (!stall && !stall_ext) begin rd = d_rdata; ins = instr; break; end
      @(negedge clk);
      k++;
      stall_ext = (k < ext);
    end
    @(negedge clk);
    if_req = 0; d_req = 0; d_we = 0; stall_ext = 0;
  endtask

  task automatic io_wr(input logic [7:0] off, input logic [31:0] wd, output int t0);
    logic [31:0] rd, ins; int k;
    acc(0, 0, 1, 1, 32'h8000_0000 | off, wd, 0, rd, ins, k, t0);
  endtask

  task automatic io_rd(input logic [7:0] off, input int ext, output logic [31:0] rd,
                       output int t0);
    logic [31:0] ins; int k;
    acc(0, 0, 1, 0, 32'h8000_0000 | off, 0, ext, rd, ins, k, t0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, ins, exp;
    int k, t0, tw, b0, b1, b2, b3, nr;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("reset stall_o", {31'b0, stall}, 0);
    chk("reset gfx_args R10", gfx_args[31:0] | gfx_args[127:96], 0);
    chk("reset tx_valid R9", {31'b0, tx_valid}, 0);

    // R1/R3 directed routing with latencies
    dc_lat = 3; b0 = n_dc;
    acc(0, 0, 1, 0, 32'h1000_0040, 0, 0, rd, ins, k, t0);
    chk("R1 dcache read data", rd, mdl(32'h1000_0040, 8'h11));
    chk("R3 dcache latency", k, 3);
    chk("R1 single dcache request", n_dc - b0, 1);
    dc_lat = 2;
    acc(0, 0, 1, 1, 32'h3000_0100, 32'hdead_beef, 0, rd, ins, k, t0);
    chk("R3 dcache write latency", k, 2);
    rom_lat = 1; b0 = n_rom;
    acc(0, 0, 1, 0, 32'h4000_0100, 0, 0, rd, ins, k, t0);
    chk("R1 rom read data", rd, mdl(32'h4000_0100, 8'h44));
    chk("R1 single rom request", n_rom - b0, 1);
    by_lat = 4; b0 = n_by;
    acc(0, 0, 1, 0, 32'hC000_0008, 0, 0, rd, ins, k, t0);
    chk("R1 bypass read data", rd, mdl(32'hC000_0008, 8'h99));
    chk("R3 bypass latency", k, 4);
    chk("R1 single bypass request", n_by - b0, 1);

    // R2 unmapped and ROM write
    b0 = n_dc; b1 = n_rom; b2 = n_by;
    acc(0, 0, 1, 0, 32'h2000_0000, 0, 0, rd, ins, k, t0);
    chk("R2 unmapped reads zero", rd, 0);
    chk("R2 unmapped no stall", k, 0);
    acc(0, 0, 1, 1, 32'h4000_0010, 32'h1, 0, rd, ins, k, t0);
    chk("R2 rom write no stall", k, 0);
    chk("R2 no requests", (n_dc - b0) + (n_rom - b1) + (n_by - b2), 0);

    // R5 fetch, R4 hold of early data response
    ic_lat = 6; dc_lat = 2; b0 = n_dc; b1 = n_ic;
    acc(1, 32'h4000_0200, 1, 0, 32'h1000_0ab0, 0, 0, rd, ins, k, t0);
    chk("R4 held dcache data", rd, mdl(32'h1000_0ab0, 8'h11));
    chk("R5 fetched instruction", ins, mdl(32'h4000_0200, 8'h5e));
    chk("R4 completion waits slow fetch", k, 6);
    chk("R4 no reissue", (n_dc - b0) * 16 + (n_ic - b1), 17);
    ic_lat = 1; by_lat = 1; b0 = n_by;
    acc(1, 32'h4000_0204, 1, 0, 32'hF000_0020, 0, 3, rd, ins, k, t0);
    chk("R4 held under external stall", rd, mdl(32'hF000_0020, 8'h99));
    chk("R5 instr under external stall", ins, mdl(32'h4000_0204, 8'h5e));
    chk("R4 external stall length", k, 3);
    chk("R4 bypass not reissued", n_by - b0, 1);

    // R6 cycle counter with hold
    io_wr(8'h10, 0, tw);
    repeat (5) @(negedge clk);
    io_rd(8'h10, 0, rd, t0);
    chk("R6 cycle count after clear", rd, t0 - tw - 1);
    io_wr(8'h10, 0, tw);
    repeat (2) @(negedge clk);
    io_rd(8'h10, 4, rd, t0);
    chk("R6 R4 cycle count held at issue", rd, t0 - tw - 1);

    // R7 instruction counter
    io_wr(8'h14, 0, tw);
    nr = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      retire = $urandom_range(0, 1);
      if (retire) nr++;
    end
    @(negedge clk); retire = 0;
    io_rd(8'h14, 0, rd, t0);
    chk("R7 retired count", rd, nr);
    io_wr(8'h14, 0, tw);
    io_rd(8'h14, 0, rd, t0);
    chk("R7 cleared by write", rd, 0);

    // R8 serial receive
    tx_ready = 1;
    io_rd(8'h00, 0, rd, t0);
    chk("R8 status idle", rd, 32'h1);
    @(negedge clk); rx_valid = 1; rx_data = 8'hC3;
    @(negedge clk); rx_valid = 0;
    io_wr(8'h04, 32'h55, t0);
    io_wr(8'h00, 32'h0, t0);
    tx_ready = 0;
    io_rd(8'h00, 0, rd, t0);
    chk("R8 R11 status rx valid after ro writes", rd, 32'h2);
    io_rd(8'h04, 2, rd, t0);
    chk("R8 R11 rx byte", rd, 32'hC3);
    io_rd(8'h00, 0, rd, t0);
    chk("R8 rx valid cleared", rd, 32'h0);

    // R9 transmit
    b0 = n_tx;
    io_wr(8'h08, 32'h1A5, t0);
    chk("R9 no pulse when not ready", n_tx - b0, 0);
    tx_ready = 1;
    io_wr(8'h08, 32'h1A5, t0);
    chk("R9 one pulse when ready", n_tx - b0, 1);
    chk("R9 tx byte", {24'b0, tx_last}, 32'hA5);

    // R10 drawing registers
    for (int i = 0; i < 4; i++) io_wr(8'h40 + 8'(4 * i), 32'hA000_0000 + i * 32'h111, t0);
    for (int i = 0; i < 4; i++) begin
      io_rd(8'h40 + 8'(4 * i), 0, rd, t0);
      chk("R10 arg readback", rd, 32'hA000_0000 + i * 32'h111);
      chk("R10 arg output", gfx_args[32*i +: 32], 32'hA000_0000 + i * 32'h111);
    end
    b0 = n_go;
    io_wr(8'h24, 32'h1, t0);
    chk("R10 start pulse", n_go - b0, 1);
    gfx_busy = 1;
    io_wr(8'h20, 32'h0, t0);
    io_rd(8'h20, 0, rd, t0);
    chk("R10 R11 busy status", rd, 1);
    gfx_busy = 0;

    // R11 write-only and unassigned reads
    io_rd(8'h08, 0, rd, t0);
    chk("R11 tx reg reads zero", rd, 0);
    io_rd(8'h24, 0, rd, t0);
    chk("R11 start reg reads zero", rd, 0);
    io_rd(8'h0C, 0, rd, t0);
    chk("R11 unassigned reads zero", rd, 0);

    // random mix
    for (int it = 0; it < 200; it++) begin
      logic [3:0]  nib;
      logic [31:0] a, p;
      logic        we, fi;
      int          ext, ek, dl;
      nib = 4'($urandom_range(0, 15));
      if (nib == 4'h8) nib = 4'h9;
      a  = {nib, 28'($urandom) & 28'hFFF_FFFC};
      p  = {4'h4, 28'($urandom) & 28'hFFF_FFFC};
      we = 1'($urandom_range(0, 1));
      fi = 1'($urandom_range(0, 1));
      ext = $urandom_range(0, 3);
      ic_lat = $urandom_range(1, 5); dc_lat = $urandom_range(1, 5);
      rom_lat = $urandom_range(1, 5); by_lat = $urandom_range(1, 5);
      b0 = n_dc; b1 = n_rom; b2 = n_by; b3 = n_ic;
      if (nib == 4'h1 || nib == 4'h3) begin dl = dc_lat; exp = mdl(a, 8'h11); end
      else if (nib == 4'h4)           begin dl = we ? 0 : rom_lat; exp = mdl(a, 8'h44); end
      else if (nib >= 4'h9)           begin dl = by_lat; exp = mdl(a, 8'h99); end
      else                            begin dl = 0; exp = 0; end
      ek = ext;
      if (dl > ek) ek = dl;
      if (fi && ic_lat > ek) ek = ic_lat;
      acc(fi, p, 1, we, a, $urandom, ext, rd, ins, k, t0);
      chk("R3 R4 random completion cycle", k, ek);
      if (!we) chk("R1 R2 R4 random read data", rd, exp);
      if (fi) chk("R5 random fetch", ins, mdl(p, 8'h5e));
      chk("R1 R2 random request counts",
          {8'(n_dc - b0), 8'(n_rom - b1), 8'(n_by - b2), 8'(n_ic - b3)},
          {8'((nib == 4'h1 || nib == 4'h3) ? 1 : 0), 8'((nib == 4'h4 && !we) ? 1 : 0),
           8'((nib >= 4'h9) ? 1 : 0), 8'(fi ? 1 : 0)});
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule